// File: doc/BRIEF.md
# Loss-Priority Push-Out Cell Buffer

This block is a single first-in first-out queue of cells in which every cell carries a one-bit loss priority next to its tag. A low-priority cell (loss bit 1) is the first to be sacrificed whenever space runs short. An arriving high-priority cell (loss bit 0) that meets a full queue evicts one stored low-priority cell. The evicted cell is either the one closest to the head or the one closest to the tail, as a configuration bit selects. Two admission rules apply to low-priority arrivals only: a programmable occupancy threshold reserves space for high-priority traffic, and an optional cap bounds how many low-priority cells may be stored at once.

Storage is a shift-compaction array with slot 0 as the head. A dequeue removes slot 0. A push-out removes the victim slot. In both cases every younger entry moves down one place in the same clock cycle. Each cycle an admission outcome is decided: ADM_IDLE (no arrival), ADM_STORE (arrival appended), ADM_PUSH (arrival appended after eviction), ADM_DROP_FULL, ADM_DROP_THRESH or ADM_DROP_CAP. That outcome is loaded into a registered outcome state, so the state moves from any outcome to any other outcome on every edge. The drop and push-out pulses are decoded from this state one cycle after the arrival.

Top module: `cpb_pushout_buffer`

## Requirements
- R1: After reset the queue is empty: occupancy 0, low_count 0, deq_valid 0, drop_o 0, push_o 0.
- R2: Cells leave in arrival order. While deq_valid is 1, deq_tag and deq_low show the oldest stored cell. A cycle with deq_req high and a non-empty queue removes that cell.
- R3: Occupancy never exceeds DEPTH. A low-priority arrival (enq_low=1) that finds the queue full after any same-cycle dequeue is discarded, and drop_o is 1 in the following cycle.
- R4: A high-priority arrival (enq_low=0) that finds the queue full while at least one low-priority cell is stored is admitted. Exactly one low-priority cell is removed, push_o is 1 in the following cycle, occupancy stays at DEPTH and low_count falls by one.
- R5: With cfg_push_tail=0 the evicted cell is the stored low-priority cell nearest the head.
- R6: With cfg_push_tail=1 the evicted cell is the stored low-priority cell nearest the tail.
- R7: A high-priority arrival that finds the queue full with no low-priority cell stored is discarded, and drop_o is 1 in the following cycle.
- R8: A low-priority arrival is discarded when the occupancy, taken after any same-cycle dequeue, is greater than cfg_thresh. High-priority arrivals are not affected by the threshold.
- R9: When cfg_cap_en=1, a low-priority arrival is discarded if the stored low-priority count, taken after any same-cycle dequeue, is at least cfg_cap.
- R10: When an enqueue and a dequeue happen in the same cycle, the dequeue is applied first. An arrival into a full queue that is also being read is therefore stored without any push-out or drop.
- R11: low_count always equals the number of stored cells that have the loss bit set.
- R12: drop_o and push_o are single-cycle pulses that follow the arrival by one cycle, and they are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_push_tail | input | 1 | Eviction end: 0 selects the low cell nearest the head, 1 the one nearest the tail |
| cfg_thresh | input | CNT_W | Occupancy above which low-priority arrivals are refused |
| cfg_cap_en | input | 1 | Enables the low-priority storage cap |
| cfg_cap | input | CNT_W | Maximum number of stored low-priority cells |
| enq_valid | input | 1 | Arrival present this cycle |
| enq_tag | input | TAG_W | Tag of the arriving cell |
| enq_low | input | 1 | Loss bit of the arriving cell (1 = low priority) |
| deq_req | input | 1 | Request to remove the head cell |
| deq_valid | output | 1 | Queue holds at least one cell |
| deq_tag | output | TAG_W | Tag of the head cell |
| deq_low | output | 1 | Loss bit of the head cell |
| drop_o | output | 1 | Arrival of the previous cycle was discarded |
| push_o | output | 1 | A stored cell was evicted in the previous cycle |
| occupancy | output | CNT_W | Number of stored cells |
| low_count | output | CNT_W | Number of stored low-priority cells |

## Verification
The assertions assume that the configuration inputs change only while the queue is idle and empty. The cap property reads cfg_cap and cfg_cap_en as steady across the cycle it examines. The bench honours this: it selects each eviction mode, threshold and cap setting only after the queue has drained, and holds it for the whole traffic run that follows. Arrivals and dequeue requests come from a bench-side pseudo-random sequence that keeps the queue near full. Directed fills place low-priority cells at known slots so that each eviction end can be identified from the drain order.

// File: rtl/cpb_pkg.sv
package cpb_pkg;

    // Outcome of the admission decision for one cycle
    typedef enum logic [2:0] {
        ADM_IDLE        = 3'd0,
        ADM_STORE       = 3'd1,
        ADM_PUSH        = 3'd2,
        ADM_DROP_FULL   = 3'd3,
        ADM_DROP_THRESH = 3'd4,
        ADM_DROP_CAP    = 3'd5
    } adm_e;

endpackage

// File: rtl/cpb_admit.sv
module cpb_admit
    import cpb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             enq_valid,
    input  logic             enq_low,
    input  logic [CNT_W-1:0] occ_eff,
    input  logic [CNT_W-1:0] low_eff,
    input  logic [CNT_W-1:0] cfg_thresh,
    input  logic             cfg_cap_en,
    input  logic [CNT_W-1:0] cfg_cap,
    output adm_e             outcome
);

    localparam logic [CNT_W-1:0] FULL_V = CNT_W'(DEPTH);

    logic full_eff;
    assign full_eff = (occ_eff == FULL_V);

    always_comb begin
        outcome = ADM_IDLE;
        if (enq_valid) begin
            if (enq_low) begin
                // low-priority: reservation threshold, cap, then space
                if (occ_eff > cfg_thresh)
                    outcome = ADM_DROP_THRESH;
                else if (cfg_cap_en && (low_eff >= cfg_cap))
                    outcome = ADM_DROP_CAP;
                else if (full_eff)
                    outcome = ADM_DROP_FULL;
                else
                    outcome = ADM_STORE;
            end else begin
                // high-priority: evict a low cell when no room is left
                if (!full_eff)
                    outcome = ADM_STORE;
                else if (low_eff != '0)
                    outcome = ADM_PUSH;
                else
                    outcome = ADM_DROP_FULL;
            end
        end
    end

endmodule

// File: rtl/cpb_victim_sel.sv
module cpb_victim_sel #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] low_vec,
    input  logic             from_tail,
    output logic [IDX_W-1:0] victim_idx,
    output logic             victim_hit
);

    logic [IDX_W-1:0] head_idx, tail_idx;
    logic             head_hit, tail_hit;

    // nearest to head: scan downward so the lowest index wins
    always_comb begin
        head_idx = '0;
        head_hit = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (low_vec[i]) begin
                head_idx = IDX_W'(i);
                head_hit = 1'b1;
            end
        end
    end

    // nearest to tail: scan upward so the highest index wins
    always_comb begin
        tail_idx = '0;
        tail_hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (low_vec[i]) begin
                tail_idx = IDX_W'(i);
                tail_hit = 1'b1;
            end
        end
    end

    assign victim_idx = from_tail ? tail_idx : head_idx;
    assign victim_hit = from_tail ? tail_hit : head_hit;

endmodule

// File: rtl/cpb_shift_array.sv
module cpb_shift_array #(
    parameter int DEPTH = 16,
    parameter int ENT_W = 9,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rm_en,
    input  logic [IDX_W-1:0] rm_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_pos,
    input  logic [ENT_W-1:0] wr_data,
    output logic [ENT_W-1:0] slot_q [DEPTH]
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic hit_wr, hit_shift;
        assign hit_wr    = wr_en && (wr_pos == IDX_W'(i));
        assign hit_shift = rm_en && (rm_idx <= IDX_W'(i));

        if (i == DEPTH - 1) begin : g_last
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot_q[i] <= '0;
                else if (hit_wr)
                    slot_q[i] <= wr_data;
                else if (hit_shift)
                    slot_q[i] <= '0;
            end
        end else begin : g_mid
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot_q[i] <= '0;
                else if (hit_wr)
                    slot_q[i] <= wr_data;
                else if (hit_shift)
                    slot_q[i] <= slot_q[i+1];
            end
        end
    end

endmodule

// File: rtl/cpb_pushout_buffer.sv
module cpb_pushout_buffer
    import cpb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TAG_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_push_tail,
    input  logic [$clog2(DEPTH+1)-1:0]  cfg_thresh,
    input  logic                        cfg_cap_en,
    input  logic [$clog2(DEPTH+1)-1:0]  cfg_cap,
    input  logic                        enq_valid,
    input  logic [TAG_W-1:0]            enq_tag,
    input  logic                        enq_low,
    input  logic                        deq_req,
    output logic                        deq_valid,
    output logic [TAG_W-1:0]            deq_tag,
    output logic                        deq_low,
    output logic                        drop_o,
    output logic                        push_o,
    output logic [$clog2(DEPTH+1)-1:0]  occupancy,
    output logic [$clog2(DEPTH+1)-1:0]  low_count
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int ENT_W = TAG_W + 1;

    logic [CNT_W-1:0] count_q, low_q;
    adm_e             outcome_q, outcome_d;

    logic [ENT_W-1:0] slot_q [DEPTH];
    logic [DEPTH-1:0] low_vec;
    logic             deq_fire, head_low;
    logic [CNT_W-1:0] occ_eff, low_eff;
    logic [IDX_W-1:0] victim_idx;
    logic             victim_hit;
    logic             rm_en, wr_en, is_push, is_store;
    logic [IDX_W-1:0] rm_idx, wr_pos;
    logic [CNT_W-1:0] wr_pos_full;

    // ---------------- occupancy seen by the arrival ----------------
    assign head_low = slot_q[0][0];
    assign deq_fire = deq_req && (count_q != '0);
    assign occ_eff  = count_q - CNT_W'(deq_fire);
    assign low_eff  = low_q - CNT_W'(deq_fire && head_low);

    for (genvar i = 0; i < DEPTH; i++) begin : g_lowvec
        assign low_vec[i] = slot_q[i][0] && (CNT_W'(i) < count_q);
    end

    cpb_admit #(.DEPTH(DEPTH)) u_admit (
        .enq_valid  (enq_valid),
        .enq_low    (enq_low),
        .occ_eff    (occ_eff),
        .low_eff    (low_eff),
        .cfg_thresh (cfg_thresh),
        .cfg_cap_en (cfg_cap_en),
        .cfg_cap    (cfg_cap),
        .outcome    (outcome_d)
    );

    cpb_victim_sel #(.DEPTH(DEPTH)) u_victim (
        .low_vec    (low_vec),
        .from_tail  (cfg_push_tail),
        .victim_idx (victim_idx),
        .victim_hit (victim_hit)
    );

    // ---------------- array control ----------------
    assign is_push  = (outcome_d == ADM_PUSH) && victim_hit;
    assign is_store = (outcome_d == ADM_STORE);

    // a push only occurs on a full queue with no dequeue, so the two removals never coincide
    assign rm_en       = deq_fire || is_push;
    assign rm_idx      = deq_fire ? '0 : victim_idx;
    assign wr_en       = is_store || is_push;
    assign wr_pos_full = occ_eff - CNT_W'(is_push);
    assign wr_pos      = IDX_W'(wr_pos_full);

    cpb_shift_array #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rm_en   (rm_en),
        .rm_idx  (rm_idx),
        .wr_en   (wr_en),
        .wr_pos  (wr_pos),
        .wr_data ({enq_tag, enq_low}),
        .slot_q  (slot_q)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            low_q     <= '0;
            outcome_q <= ADM_IDLE;
        end else begin
            count_q   <= occ_eff + CNT_W'(is_store);
            low_q     <= low_eff + CNT_W'(is_store && enq_low) - CNT_W'(is_push);
            outcome_q <= outcome_d;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        drop_o = 1'b0;
        push_o = 1'b0;
        unique case (outcome_q)
            ADM_IDLE, ADM_STORE: ;
            ADM_PUSH:            push_o = 1'b1;
            ADM_DROP_FULL,
            ADM_DROP_THRESH,
            ADM_DROP_CAP:        drop_o = 1'b1;
            default: ;
        endcase
    end

    assign deq_valid = (count_q != '0);
    assign deq_tag   = slot_q[0][ENT_W-1:1];
    assign deq_low   = slot_q[0][0];
    assign occupancy = count_q;
    assign low_count = low_q;

endmodule

// File: rtl/cpb_checker.sv
module cpb_checker #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_cap_en,
    input logic [CNT_W-1:0] cfg_cap,
    input logic             enq_valid,
    input logic             deq_req,
    input logic             deq_valid,
    input logic             drop_o,
    input logic             push_o,
    input logic [CNT_W-1:0] occupancy,
    input logic [CNT_W-1:0] low_count
);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH));

    a_r11_low_within: assert property (@(posedge clk) disable iff (!rst_n)
        low_count <= occupancy);

    a_r12_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drop_o, push_o}));

    a_r4_push_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> (occupancy == CNT_W'(DEPTH)));

    a_r4_push_takes_low: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> (low_count == $past(low_count) - 1'b1));

    a_r9_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cap_en && $stable(cfg_cap) && $stable(cfg_cap_en) && (low_count >= cfg_cap))
        |=> (low_count <= $past(low_count)));

    a_r10_deq_first: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_req && deq_valid && enq_valid && (occupancy == CNT_W'(DEPTH))) |=> !push_o);

    a_r2_deq_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_req && deq_valid && !enq_valid) |=> (occupancy == $past(occupancy) - 1'b1));

endmodule

bind cpb_pushout_buffer cpb_checker #(.DEPTH(DEPTH)) u_cpb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_cap_en (cfg_cap_en),
    .cfg_cap    (cfg_cap),
    .enq_valid  (enq_valid),
    .deq_req    (deq_req),
    .deq_valid  (deq_valid),
    .drop_o     (drop_o),
    .push_o     (push_o),
    .occupancy  (occupancy),
    .low_count  (low_count)
);

// File: tb/cpb_pushout_buffer_bench.sv
module cpb_pushout_buffer_bench;

    localparam int DEPTH = 16;
    localparam int TAG_W = 8;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_push_tail = 1'b0;
    logic [CNT_W-1:0] cfg_thresh = CNT_W'(DEPTH);
    logic             cfg_cap_en = 1'b0;
    logic [CNT_W-1:0] cfg_cap = '0;
    logic             enq_valid = 1'b0;
    logic [TAG_W-1:0] enq_tag = '0;
    logic             enq_low = 1'b0;
    logic             deq_req = 1'b0;
    logic             deq_valid, deq_low, drop_o, push_o;
    logic [TAG_W-1:0] deq_tag;
    logic [CNT_W-1:0] occupancy, low_count;

    always #5 clk = ~clk;

    cpb_pushout_buffer #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_cpb_pushout_buffer (
        .clk(clk), .rst_n(rst_n), .cfg_push_tail(cfg_push_tail), .cfg_thresh(cfg_thresh),
        .cfg_cap_en(cfg_cap_en), .cfg_cap(cfg_cap), .enq_valid(enq_valid), .enq_tag(enq_tag),
        .enq_low(enq_low), .deq_req(deq_req), .deq_valid(deq_valid), .deq_tag(deq_tag),
        .deq_low(deq_low), .drop_o(drop_o), .push_o(push_o), .occupancy(occupancy),
        .low_count(low_count)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench-side reference queue
    int m_tag [DEPTH];
    int m_low [DEPTH];
    int m_n = 0;
    int lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int next_rand();
        int b;
        b = ((lfsr >> 0) ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1;
        lfsr = ((lfsr >> 1) | (b << 15)) & 16'hFFFF;
        return lfsr;
    endfunction

    // one cycle of stimulus with expected values from the requirements
    task automatic step(input bit e, input int t, input bit l, input bit d, input string lbl);
        bit deqf, exp_drop, exp_push;
        int occ, lc, v;
        string why;
        @(negedge clk);
        enq_valid = e; enq_tag = TAG_W'(t); enq_low = l; deq_req = d;
        deqf = d && (m_n > 0);
        if (deqf) begin
            chk(deq_valid == 1'b1, "R2 head valid", deq_valid, 1);
            chk(deq_tag == TAG_W'(m_tag[0]), {"R2 head order ", lbl}, deq_tag, m_tag[0]);
            chk(deq_low == m_low[0][0], "R2 head loss bit", deq_low, m_low[0]);
            for (int i = 0; i < DEPTH - 1; i++) begin
                m_tag[i] = m_tag[i+1]; m_low[i] = m_low[i+1];
            end
            m_n--;
        end
        occ = m_n;
        lc = 0;
        for (int i = 0; i < m_n; i++) lc += m_low[i];
        exp_drop = 0; exp_push = 0; why = "R12";
        if (e) begin
            if (l) begin
                if (occ > int'(cfg_thresh)) begin exp_drop = 1; why = "R8 threshold"; end
                else if (cfg_cap_en && lc >= int'(cfg_cap)) begin exp_drop = 1; why = "R9 cap"; end
                else if (occ == DEPTH) begin exp_drop = 1; why = "R3 full low"; end
            end else if (occ == DEPTH) begin
                if (lc > 0) begin exp_push = 1; why = "R4 push-out"; end
                else begin exp_drop = 1; why = "R7 full no low"; end
            end else if (d && m_n == DEPTH - 1) why = "R10 dequeue first";
            if (exp_push) begin
                v = -1;
                for (int i = 0; i < DEPTH; i++)
                    if (m_low[i] == 1 && (cfg_push_tail || v < 0)) v = i;
                for (int i = v; i < DEPTH - 1; i++) begin
                    m_tag[i] = m_tag[i+1]; m_low[i] = m_low[i+1];
                end
                m_n--;
            end
            if (!exp_drop) begin
                m_tag[m_n] = t; m_low[m_n] = l; m_n++;
            end
        end
        @(posedge clk);
        #1;
        lc = 0;
        for (int i = 0; i < m_n; i++) lc += m_low[i];
        chk(drop_o == exp_drop, {why, " drop pulse"}, drop_o, exp_drop);
        chk(push_o == exp_push, {why, " push pulse"}, push_o, exp_push);
        chk(int'(occupancy) == m_n, "R3 occupancy", occupancy, m_n);
        chk(int'(low_count) == lc, "R11 low count", low_count, lc);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, "idle");
    endtask

    task automatic drain(input string lbl);
        while (m_n > 0) step(0, 0, 0, 1, lbl);
        idle();
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(occupancy == 0, "R1 occupancy", occupancy, 0);
        chk(low_count == 0, "R1 low count", low_count, 0);
        chk(deq_valid == 0, "R1 deq_valid", deq_valid, 0);
        chk(drop_o == 0 && push_o == 0, "R1 pulses", {drop_o, push_o}, 0);

        for (int mode = 0; mode < 2; mode++) begin
            cfg_push_tail = mode[0];
            cfg_thresh = CNT_W'(DEPTH); cfg_cap_en = 0;
            // directed: low cells at slots 3 and 12, then a high arrival evicts one (R5 / R6)
            for (int i = 0; i < DEPTH; i++) step(1, i, (i == 3 || i == 12), 0, "fill");
            step(1, 99, 0, 0, "R4 push");
            drain(mode ? "R6 tail victim" : "R5 head victim");
            // directed: all-high full queue refuses a high arrival (R7)
            for (int i = 0; i < DEPTH; i++) step(1, 20 + i, 0, 0, "fill");
            step(1, 77, 0, 0, "R7");
            step(1, 78, 1, 0, "R3");
            step(1, 79, 0, 1, "R10");   // full queue with simultaneous read
            drain("R2 order");
            // pseudo-random sweeps over threshold and cap settings
            for (int c = 0; c < 4; c++) begin
                case (c)
                    0: begin cfg_thresh = CNT_W'(DEPTH); cfg_cap_en = 0; cfg_cap = 0; end
                    1: begin cfg_thresh = 10; cfg_cap_en = 0; cfg_cap = 0; end
                    2: begin cfg_thresh = CNT_W'(DEPTH); cfg_cap_en = 1; cfg_cap = 5; end
                    default: begin cfg_thresh = 12; cfg_cap_en = 1; cfg_cap = 3; end
                endcase
                idle();
                for (int k = 0; k < 400; k++) begin
                    int r;
                    r = next_rand();
                    step((r & 7) != 0, (r >> 4) & 8'hFF, (r >> 3) & 1, ((r >> 12) & 3) == 0, "R2 sweep");
                end
                drain("R2 drain");
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule